// File: doc/BRIEF.md
# Paged and Indirect Data Address Generator

This unit turns an addressing request into a data-memory address for a processor datapath. It keeps two kinds of pointer state: a bank of eight 16-bit pointer registers and one page register. A direct request joins the page register (upper bits) with a short in-page offset (lower six bits), so each page spans 64 words. An indirect request emits the contents of a selected pointer register and may then step that register by +1, -1 or a signed stride, with an optional wrap inside a ring buffer bounded by two inputs.

Immediate and register operands need no memory address. They are issued as the idle code, which leaves all state alone and raises no address strobe. Two load codes write the page register or a pointer register from the data input. Every result is registered, so the address and the register update report appear one clock after the request. A pointer register that is written is visible to the very next request.

Top module: `dag_top`

## Requirements
- R1: After synchronous reset, all outputs are zero, every pointer register holds zero and the page register holds zero.
- R2: Op code 1 (direct) gives, one cycle later, ea_o = {page register, off_i} with ea_vld_o = 1; off_i fills the low OFF_W bits.
- R3: Op code 3 (page load) stores data_i[ADDR_W-OFF_W-1:0] in the page register; the upper bits of data_i are ignored. No other op code changes the page register.
- R4: Op code 4 (pointer load) writes data_i into pointer register sel_i and, one cycle later, reports upd_vld_o = 1, upd_sel_o = sel_i and upd_val_o = data_i.
- R5: Op code 2 (indirect) gives, one cycle later, ea_o equal to the value pointer register sel_i held before any post-modification, with ea_vld_o = 1.
- R6: With circ_i = 0, indirect post-modify code mod_i = 1 adds 1, code 2 subtracts 1 and code 3 adds step_i read as a two's-complement number, all modulo 2^ADDR_W; the new value is reported on upd_val_o with upd_vld_o = 1.
- R7: With circ_i = 1 and mod_i = 1, a register value greater than or equal to buf_hi_i is replaced by buf_lo_i; otherwise it is incremented.
- R8: With circ_i = 1 and mod_i = 2, a register value less than or equal to buf_lo_i is replaced by buf_hi_i; otherwise it is decremented.
- R9: With circ_i = 1 and mod_i = 3, a non-negative step whose exact sum exceeds buf_hi_i loads buf_lo_i, a negative step whose exact sum falls below buf_lo_i loads buf_hi_i, and any other sum is stored as is.
- R10: Op code 0 and the unused codes 5 to 7 change no state and give ea_vld_o = 0 and upd_vld_o = 0; an indirect request with mod_i = 0 gives upd_vld_o = 0 and leaves the register unchanged.
- R11: A pointer register written by a request is read with its new value by the request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Request code: 0 idle, 1 direct, 2 indirect, 3 page load, 4 pointer load |
| sel_i | input | SEL_W | Pointer register select |
| mod_i | input | 2 | Post-modify: 0 none, 1 +1, 2 -1, 3 +step |
| circ_i | input | 1 | Ring-buffer wrap enable for post-modify |
| off_i | input | OFF_W | In-page offset for direct requests |
| data_i | input | ADDR_W | Load value for page or pointer loads |
| step_i | input | ADDR_W | Signed stride for mod_i = 3 |
| buf_lo_i | input | ADDR_W | Ring buffer first address |
| buf_hi_i | input | ADDR_W | Ring buffer last address |
| ea_o | output | ADDR_W | Effective address |
| ea_vld_o | output | 1 | Effective address valid |
| upd_vld_o | output | 1 | A pointer register was written |
| upd_sel_o | output | SEL_W | Index of the written pointer register |
| upd_val_o | output | ADDR_W | Value written to it |

## Verification
The bench builds the unit with an 8-bit address, a 3-bit offset and four pointer registers, which leaves a 5-bit page register. That shrinks the space enough to load every 8-bit value into a pointer register and apply each post-modify code, linear and ring-buffer, against a wide window and a one-entry window. Every page value with several settings of the ignored upper bits, and every offset, is also swept. Expected addresses and wrap results are computed with integer arithmetic in the bench.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DIR   = 3'd1,
    OP_IND   = 3'd2,
    OP_PAGE  = 3'd3,
    OP_LDPTR = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_STEP = 2'd3
  } pm_e;

endpackage

// File: rtl/dag_arfile.sv
module dag_arfile #(
  parameter int NUM   = 8,
  parameter int WIDTH = 16,
  parameter int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [WIDTH-1:0] rd_val,
  input  logic             we,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_val
);

  logic [WIDTH-1:0] regs [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wr_sel] <= wr_val;
    end
  end

  assign rd_val = regs[rd_sel];

  // R11: a write is visible at the read port in the next cycle
  p_write_seen_r11: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(wr_sel)] == $past(wr_val)));

endmodule

// File: rtl/dag_postmod.sv
module dag_postmod
  import dag_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  pm_e              mode,
  input  logic             circ,
  input  logic [WIDTH-1:0] lo,
  input  logic [WIDTH-1:0] hi,
  input  logic [WIDTH-1:0] step,
  output logic [WIDTH-1:0] nxt
);

  localparam int EW = WIDTH + 2;

  logic signed [EW-1:0] cur_x, lo_x, hi_x, step_x, sum_x;
  logic [WIDTH-1:0]     inc_v, dec_v, step_v;

  always_comb begin
    cur_x  = $signed({2'b00, cur});
    lo_x   = $signed({2'b00, lo});
    hi_x   = $signed({2'b00, hi});
    step_x = $signed({{2{step[WIDTH-1]}}, step});
    sum_x  = cur_x + step_x;

    // increment, with ring wrap when at or past the last entry
    if (circ && (cur >= hi)) inc_v = lo;
    else                     inc_v = cur + 1'b1;

    // decrement, with ring wrap when at or below the first entry
    if (circ && (cur <= lo)) dec_v = hi;
    else                     dec_v = cur - 1'b1;

    // signed stride, wrap direction follows the stride sign
    if (circ && !step[WIDTH-1] && (sum_x > hi_x))      step_v = lo;
    else if (circ && step[WIDTH-1] && (sum_x < lo_x))  step_v = hi;
    else                                               step_v = sum_x[WIDTH-1:0];

    unique case (mode)
      PM_INC:  nxt = inc_v;
      PM_DEC:  nxt = dec_v;
      PM_STEP: nxt = step_v;
      default: nxt = cur;
    endcase
  end

  // R7/R8: single steps in ring mode never leave a well-formed window
  always_comb begin
    if (circ && (lo <= hi) && (cur >= lo) && (cur <= hi) &&
        ((mode == PM_INC) || (mode == PM_DEC))) begin
      p_ring_bounds_r7: assert ((nxt >= lo) && (nxt <= hi));
    end
  end

endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6,
  parameter int NUM_AR = 8,
  parameter int SEL_W  = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        mod_i,
  input  logic              circ_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [ADDR_W-1:0] buf_lo_i,
  input  logic [ADDR_W-1:0] buf_hi_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_vld_o,
  output logic              upd_vld_o,
  output logic [SEL_W-1:0]  upd_sel_o,
  output logic [ADDR_W-1:0] upd_val_o
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  op_e               op;
  pm_e               pm;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] ptr_cur, ptr_nxt, wr_val;
  logic              is_dir, is_ind, is_page, is_ld, wr_en;

  always_comb begin
    op      = op_e'(op_i);
    pm      = pm_e'(mod_i);
    is_dir  = (op == OP_DIR);
    is_ind  = (op == OP_IND);
    is_page = (op == OP_PAGE);
    is_ld   = (op == OP_LDPTR);
    wr_en   = !rst && (is_ld || (is_ind && (pm != PM_NONE)));
    wr_val  = is_ld ? data_i : ptr_nxt;
  end

  dag_arfile #(
    .NUM   (NUM_AR),
    .WIDTH (ADDR_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .rd_sel (sel_i),
    .rd_val (ptr_cur),
    .we     (wr_en),
    .wr_sel (sel_i),
    .wr_val (wr_val)
  );

  dag_postmod #(
    .WIDTH (ADDR_W)
  ) u_pmod (
    .cur  (ptr_cur),
    .mode (pm),
    .circ (circ_i),
    .lo   (buf_lo_i),
    .hi   (buf_hi_i),
    .step (step_i),
    .nxt  (ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (is_page) begin
      page_q <= data_i[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_o      <= '0;
      ea_vld_o  <= 1'b0;
      upd_vld_o <= 1'b0;
      upd_sel_o <= '0;
      upd_val_o <= '0;
    end else begin
      ea_vld_o  <= is_dir || is_ind;
      ea_o      <= is_dir ? {page_q, off_i} : (is_ind ? ptr_cur : '0);
      upd_vld_o <= wr_en;
      upd_sel_o <= wr_en ? sel_i  : '0;
      upd_val_o <= wr_en ? wr_val : '0;
    end
  end

  // R10: idle and unused codes raise neither strobe
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'd0) || (op_i > 3'd4)) |=> (!ea_vld_o && !upd_vld_o));

  // R2: direct address joins page register and offset
  p_direct_form_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd1) |=> (ea_vld_o && (ea_o == {$past(page_q), $past(off_i)})));

  // R3: only a page load moves the page register
  p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i != 3'd3) |=> $stable(page_q));

  // R4: a pointer load is reported with its select and value
  p_load_report_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd4) |=> (upd_vld_o && (upd_sel_o == $past(sel_i)) &&
                        (upd_val_o == $past(data_i))));

  // R5: indirect address is the register value before modification
  p_pre_mod_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd2) |=> (ea_vld_o && (ea_o == $past(ptr_cur))));

endmodule

// File: tb/sim_dag_top.sv
module sim_dag_top;

  localparam int AW = 8;
  localparam int OW = 3;
  localparam int NA = 4;
  localparam int SW = 2;
  localparam int PW = AW - OW;
  localparam int NV = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic [1:0]    mod_i = '0;
  logic          circ_i = 1'b0;
  logic [OW-1:0] off_i = '0;
  logic [AW-1:0] data_i = '0;
  logic [AW-1:0] step_i = '0;
  logic [AW-1:0] buf_lo_i = '0;
  logic [AW-1:0] buf_hi_i = '0;
  logic [AW-1:0] ea_o;
  logic          ea_vld_o;
  logic          upd_vld_o;
  logic [SW-1:0] upd_sel_o;
  logic [AW-1:0] upd_val_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dag_top #(.ADDR_W(AW), .OFF_W(OW), .NUM_AR(NA), .SEL_W(SW)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .sel_i(sel_i), .mod_i(mod_i),
    .circ_i(circ_i), .off_i(off_i), .data_i(data_i), .step_i(step_i),
    .buf_lo_i(buf_lo_i), .buf_hi_i(buf_hi_i), .ea_o(ea_o),
    .ea_vld_o(ea_vld_o), .upd_vld_o(upd_vld_o), .upd_sel_o(upd_sel_o),
    .upd_val_o(upd_val_o)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive one request at a falling edge, return at the next falling edge
  task automatic issue(int op, int sel, int md, int dat);
    op_i   = op[2:0];
    sel_i  = sel[SW-1:0];
    mod_i  = md[1:0];
    data_i = dat[AW-1:0];
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0;
  endtask

  function automatic int exp_next(int v, int m, bit c, int lo, int hi, int st);
    int s, sum;
    s = (st >= NV/2) ? st - NV : st;
    case (m)
      1: return (c && v >= hi) ? lo : (v + 1) % NV;
      2: return (c && v <= lo) ? hi : (v + NV - 1) % NV;
      3: begin
        sum = v + s;
        if (c && s >= 0 && sum > hi) return lo;
        if (c && s < 0 && sum < lo) return hi;
        return (sum + NV) % NV;
      end
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the outputs and in the stored registers
    check("R1 ea", ea_o, 0);
    check("R1 ea_vld", ea_vld_o, 0);
    check("R1 upd_vld", upd_vld_o, 0);
    check("R1 upd_val", upd_val_o, 0);
    for (int k = 0; k < NA; k++) begin
      issue(2, k, 0, 0);
      check("R1 pointer", ea_o, 0);
    end
    off_i = 3'd5;
    issue(1, 0, 0, 0);
    check("R1 page", ea_o, 5);

    // R2/R3: every page value, ignored upper data bits, every offset
    for (int p = 0; p < (1 << PW); p++) begin
      for (int hb = 0; hb < (1 << OW); hb += 3) begin
        issue(3, 0, 0, (hb << PW) | p);
        check("R10 page load strobe", ea_vld_o, 0);
        for (int o = 0; o < (1 << OW); o++) begin
          off_i = o[OW-1:0];
          issue(1, 0, 0, 0);
          check("R2 vld", ea_vld_o, 1);
          check("R3 R2 direct ea", ea_o, p * (1 << OW) + o);
        end
      end
    end

    // R4-R11: every value, every post-modify code, linear and ring
    for (int w = 0; w < 2; w++) begin
      int lo, hi;
      lo = (w == 0) ? 40 : 77;
      hi = (w == 0) ? 100 : 77;
      buf_lo_i = lo[AW-1:0];
      buf_hi_i = hi[AW-1:0];
      for (int v = 0; v < NV; v++) begin
        for (int m = 0; m < 4; m++) begin
          for (int c = 0; c < 2; c++) begin
            int k, st, e;
            string tag;
            k  = v % NA;
            st = (v * 37 + 11 + m * 53) % NV;
            step_i = st[AW-1:0];
            circ_i = c[0];
            e = exp_next(v, m, c[0], lo, hi, st);
            tag = (m == 0) ? "R10" : (c == 0) ? "R6" :
                  (m == 1) ? "R7" : (m == 2) ? "R8" : "R9";
            issue(4, k, 0, v);
            check("R4 upd_vld", upd_vld_o, 1);
            check("R4 upd_sel", upd_sel_o, k);
            check("R4 upd_val", upd_val_o, v);
            issue(2, k, m, 0);
            check("R5 pre-mod ea", ea_o, v);
            check({tag, " upd_vld"}, upd_vld_o, (m != 0) ? 1 : 0);
            if (m != 0) check({tag, " new value"}, upd_val_o, e);
            issue(2, k, 0, 0);
            check({"R11 ", tag, " written back"}, ea_o, e);
          end
        end
      end
    end

    // R10: unused codes behave as idle and leave the pointer intact
    circ_i = 1'b0;
    issue(4, 2, 0, 123);
    for (int opc = 5; opc < 8; opc++) begin
      issue(opc, 2, 1, 9);
      check("R10 unused ea_vld", ea_vld_o, 0);
      check("R10 unused upd_vld", upd_vld_o, 0);
    end
    issue(0, 2, 1, 9);
    check("R10 idle ea_vld", ea_vld_o, 0);
    issue(2, 2, 0, 0);
    check("R10 pointer kept", ea_o, 123);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule